// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block produces a steady train of timeouts from a divider that runs from reset and never pauses. Each timeout raises a sticky real-time flag in an 8-bit flag register. A companion 8-bit enable register selects which flags may raise the single interrupt output. The same two registers also hold three other flag sources: counter overflow, accumulator overflow and accumulator edge. Their timers live elsewhere and reach this block only as one-cycle set strobes.

Software reaches both registers through a plain single-cycle read/write port. A one-bit select picks the register, a write strobe commits on the clock edge, and read data is a combinational view of the selected register. A 2-bit rate input sets how far apart the timeouts are. The timeout grid is fixed by the divider alone, so how late software clears the flag never affects when the next timeout arrives.

Top module: `rti_timer`

## Requirements
- R1: While reset is low, and on the first edge after it, the enable register reads 0x00, the flag register reads 0x00 and the interrupt output is 0.
- R2: After reset is released, the real-time flag (flag bit 6) first reads 1 after exactly one full period of edges. For rate 0 this is 2^BASE_SHIFT edges, and the flag still reads 0 one edge earlier.
- R3: Timeouts fall on edge numbers (counted from reset release) that are multiples of the current period. They do not depend on when the flag was cleared.
- R4: A timeout sets flag bit 6 even when it is already set, and a set flag stays set until it is cleared.
- R5: Writing the flag register (select = 1) clears every flag bit 7:4 whose written bit is 1. Flag bits written 0 keep their value.
- R6: If a clear and a set for the same flag bit meet on one edge, the bit ends up set.
- R7: Rate select 0, 1, 2 and 3 give periods of 2^BASE_SHIFT, 2^(BASE_SHIFT+1), 2^(BASE_SHIFT+2) and 2^(BASE_SHIFT+3) edges. A change takes effect on the next edge and does not restart the divider.
- R8: Writing the enable register (select = 0) stores bits 7:4 and 1:0 of the write data. Bits 3:2 always read 0. The enables sit in bits 7 (overflow), 6 (real-time), 5 (accumulator overflow) and 4 (accumulator edge).
- R9: The interrupt output is a register that holds the OR, over bits 7:4, of flag AND enable as they stood one edge earlier. With enable bit 6 at 0, a real-time timeout still sets the flag but raises no interrupt.
- R10: A 1 on the overflow, accumulator-overflow or accumulator-edge set input sets flag bit 7, 5 or 4 on the next edge.
- R11: Flag register bits 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 enable register, 1 flag register |
| reg_wr | input | 1 | Write strobe, committed on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read of the selected register |
| rate_sel | input | 2 | Timeout period select |
| ovf_set | input | 1 | Sets flag bit 7 |
| pa_ovf_set | input | 1 | Sets flag bit 5 |
| pa_edge_set | input | 1 | Sets flag bit 4 |
| irq | output | 1 | Registered interrupt request |

## Verification
Read data follows the select in the same cycle. A register write, a set strobe or a timeout shows up in the read data one rising edge after the cycle that carries it. The interrupt output trails the flag and enable registers by one more edge, so it rises two edges after the timeout cycle. Inputs change just after a falling edge, and all outputs are compared at falling edges against a behavioural model that advances on each rising edge. The directed checks wait for an exact edge count since reset and read the flag at that count, so the first timeout, the late clear, the collision and the rate changes are each tested at the single edge where the result is due.

// File: rtl/rti_pkg.sv
// Shared constants for the real-time interrupt timer.
// Assumes an 8-bit register port with the flags in bits 7:4.
package rti_pkg;
    localparam int REG_W      = 8;
    localparam int NUM_SRC    = 4;
    localparam int SRC_LSB    = 4;
    localparam int BIT_PAEDGE = 0;   // index inside the source vector
    localparam int BIT_PAOVF  = 1;
    localparam int BIT_RTI    = 2;
    localparam int BIT_OVF    = 3;
    localparam logic [REG_W-1:0] MASK_KEEP = 8'hF3;
    localparam logic SEL_MASK = 1'b0;
    localparam logic SEL_FLAG = 1'b1;
endpackage

// File: rtl/rti_divider.sv
// Free-running divider and timeout decode.
// Assumes BASE_SHIFT >= 1. The counter width covers the longest period,
// so every shorter period divides the wrap and the grid never drifts.
module rti_divider #(
    parameter int BASE_SHIFT = 13,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick
);
    localparam int NUM_RATES = 1 << SEL_W;
    localparam int CNT_W     = BASE_SHIFT + NUM_RATES - 1;

    logic [CNT_W-1:0]     cnt_q;
    logic [NUM_RATES-1:0] hit;

    // Count every clock; only reset restarts the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // A timeout is due when the low bits of the selected width are all ones.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign hit[g] = &cnt_q[BASE_SHIFT+g-1:0];
    end

    // Pick the decode of the active rate.
    assign tick = hit[rate_sel];
endmodule

// File: rtl/rti_regs.sv
// Enable and flag registers with the read mux.
// Assumes flag sources arrive as single-cycle set strobes. A set beats a
// write-one clear on the same edge.
module rti_regs
    import rti_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [NUM_SRC-1:0] src_set,
    output logic [REG_W-1:0]   mask_q,
    output logic [REG_W-1:0]   flag_view,
    output logic [REG_W-1:0]   reg_rdata
);
    logic               mask_we;
    logic               flag_we;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] clr_req;

    assign mask_we = reg_wr && (reg_sel == SEL_MASK);
    assign flag_we = reg_wr && (reg_sel == SEL_FLAG);

    // Store the enable register; the unimplemented bits are forced to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= reg_wdata & MASK_KEEP;
    end

    // One sticky flag per source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        assign clr_req[i] = flag_we && reg_wdata[SRC_LSB+i];

        // Set wins over clear; otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (src_set[i]) flag_q[i] <= 1'b1;
            else if (clr_req[i]) flag_q[i] <= 1'b0;
        end
    end

    assign flag_view = {flag_q, {SRC_LSB{1'b0}}};

    // Return the selected register.
    always_comb begin
        reg_rdata = (reg_sel == SEL_FLAG) ? flag_view : mask_q;
    end
endmodule

// File: rtl/rti_irq.sv
// Registered interrupt combine.
// Assumes the flag and enable vectors are bit-aligned.
module rti_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         irq
);
    // Register the OR of the enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags & enables);
    end
endmodule

// File: rtl/rti_timer.sv
// Periodic real-time interrupt timer top.
// Assumes a synchronous active-low reset and single-cycle register access.
module rti_timer
    import rti_pkg::*;
#(
    parameter int BASE_SHIFT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [1:0]       rate_sel,
    input  logic             ovf_set,
    input  logic             pa_ovf_set,
    input  logic             pa_edge_set,
    output logic             irq
);
    logic               rt_tick;
    logic [NUM_SRC-1:0] src_set;
    logic [REG_W-1:0]   mask_q;
    logic [REG_W-1:0]   flag_view;

    rti_divider #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(2)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .tick     (rt_tick)
    );

    // Gather the set strobes in flag-bit order.
    always_comb begin
        src_set             = '0;
        src_set[BIT_OVF]    = ovf_set;
        src_set[BIT_RTI]    = rt_tick;
        src_set[BIT_PAOVF]  = pa_ovf_set;
        src_set[BIT_PAEDGE] = pa_edge_set;
    end

    rti_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .src_set   (src_set),
        .mask_q    (mask_q),
        .flag_view (flag_view),
        .reg_rdata (reg_rdata)
    );

    rti_irq #(.N(NUM_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flag_view[REG_W-1:SRC_LSB]),
        .enables (mask_q[REG_W-1:SRC_LSB]),
        .irq     (irq)
    );
endmodule

// File: rtl/rti_timer_checker.sv
// Property checker for rti_timer, attached by bind.
module rti_timer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr,
    input logic       sel,
    input logic [7:0] wdata,
    input logic       tick,
    input logic [7:0] flag,
    input logic [7:0] mask,
    input logic       irq,
    input logic       ovf_set
);
    // R1: reset clears every visible state on the following edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flag == 8'h00 && mask == 8'h00 && !irq));

    // R3: timeouts never come on back-to-back edges.
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4: a set real-time flag holds unless it is cleared.
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[6] && !(wr && sel && wdata[6])) |=> flag[6]);

    // R5: a write-one clear with no timeout drops the flag.
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel && wdata[6] && !tick) |=> !flag[6]);

    // R6: a timeout always leaves the flag set, even against a clear.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag[6]);

    // R9: an enabled real-time flag raises the request on the next edge.
    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[6] && mask[6]) |=> irq);

    // R9: with no enabled flag, the request is low on the next edge.
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag[7:4] & mask[7:4]) == 4'b0000) |=> !irq);

    // R10: the overflow strobe sets its flag.
    p_ext_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flag[7]);
endmodule

bind rti_timer rti_timer_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .tick    (rt_tick),
    .flag    (flag_view),
    .mask    (mask_q),
    .irq     (irq),
    .ovf_set (ovf_set)
);

// File: tb/tb_rti_timer.sv
`timescale 1ns/1ps
module tb_rti_timer;
    localparam int B = 3;   // periods 8, 16, 32, 64

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] rate_sel = 2'd0;
    logic       ovf_set = 1'b0;
    logic       pa_ovf_set = 1'b0;
    logic       pa_edge_set = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Behavioural reference state.
    int       m_e = 0;
    bit [7:0] m_mask = 0;
    bit [7:0] m_flag = 0;
    bit       m_irq = 0;

    rti_timer #(.BASE_SHIFT(B)) dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rate_sel(rate_sel),
        .ovf_set(ovf_set), .pa_ovf_set(pa_ovf_set), .pa_edge_set(pa_edge_set),
        .irq(irq)
    );

    always #5 clk = ~clk;

    // Reference model: advance once per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_e = 0; m_mask = 0; m_flag = 0; m_irq = 0;
        end else begin
            bit       nirq;
            bit [7:0] nf;
            int       per;
            nirq = (m_flag[7:4] & m_mask[7:4]) != 0;
            m_e  = m_e + 1;
            per  = 1 << (B + rate_sel);
            nf   = m_flag;
            if (reg_wr && !reg_sel) m_mask = reg_wdata & 8'hF3;
            if (reg_wr && reg_sel)  nf = nf & ~(reg_wdata & 8'hF0);
            if ((m_e % per) == 0) nf[6] = 1;
            if (ovf_set)     nf[7] = 1;
            if (pa_ovf_set)  nf[5] = 1;
            if (pa_edge_set) nf[4] = 1;
            m_flag = nf;
            m_irq  = nirq;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at edge %0d", req, act, exp, m_e);
        end
    endtask

    // Compare on every falling edge against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq", int'(irq), int'(m_irq));
            if (reg_sel) chk("R3 flag read", int'(reg_rdata), int'(m_flag));
            else         chk("R8 mask read", int'(reg_rdata), int'(m_mask));
        end
    end

    task automatic at_neg(input int n);
        if (m_e < n) begin
            while (m_e < n) @(negedge clk);
            #1;
        end
    endtask

    task automatic rd(input bit s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr_reg(input bit s, input logic [7:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: state under reset.
        rd(0, v); chk("R1 mask", int'(v), 0);
        rd(1, v); chk("R1 flag", int'(v), 0);
        chk("R1 irq", int'(irq), 0);
        #1 rst_n = 1'b1;

        at_neg(7);  rd(1, v); chk("R2 early", int'(v), 8'h00);
        at_neg(8);  rd(1, v); chk("R2 first timeout", int'(v), 8'h40);
        at_neg(16); rd(1, v); chk("R4 sticky", int'(v), 8'h40);
        at_neg(17); wr_reg(1, 8'h00);
        at_neg(18); rd(1, v); chk("R5 write zero", int'(v), 8'h40);
        at_neg(19); wr_reg(1, 8'h40);
        at_neg(20); rd(1, v); chk("R5 clear", int'(v), 8'h00);
        at_neg(23); wr_reg(1, 8'h40);
        at_neg(24); rd(1, v); chk("R6 set wins", int'(v), 8'h40);
        at_neg(29); wr_reg(1, 8'h40);
        at_neg(30); rd(1, v); chk("R3 late clear", int'(v), 8'h00);
        at_neg(31); rd(1, v); chk("R3 no early", int'(v), 8'h00);
        at_neg(32); rd(1, v); chk("R3 grid", int'(v), 8'h40);
        at_neg(33); chk("R9 disabled", int'(irq), 0);
        wr_reg(0, 8'h40);
        at_neg(34); chk("R9 lag", int'(irq), 0);
        at_neg(35); chk("R9 raise", int'(irq), 1);
        wr_reg(1, 8'h40);
        at_neg(36); chk("R9 hold", int'(irq), 1);
        at_neg(37); chk("R9 drop", int'(irq), 0);
        at_neg(38); wr_reg(0, 8'hFF);
        at_neg(39); rd(0, v); chk("R8 mask bits", int'(v), 8'hF3);
        wr_reg(0, 8'h00);
        at_neg(40); wr_reg(1, 8'hF0);
        ovf_set = 1'b1; @(negedge clk); #1 ovf_set = 1'b0;
        at_neg(42); rd(1, v); chk("R10 ovf", int'(v), 8'h80);
        pa_ovf_set = 1'b1; @(negedge clk); #1 pa_ovf_set = 1'b0;
        at_neg(43); rd(1, v); chk("R10 pa ovf", int'(v), 8'hA0);
        pa_edge_set = 1'b1; @(negedge clk); #1 pa_edge_set = 1'b0;
        at_neg(44); rd(1, v); chk("R10 pa edge", int'(v), 8'hB0);
        wr_reg(1, 8'hFF);
        at_neg(45); rd(1, v); chk("R11 low bits", int'(v), 8'h00);
        rate_sel = 2'd3;
        at_neg(48); rd(1, v); chk("R7 rate3 skip", int'(v), 8'h00);
        at_neg(63); rd(1, v); chk("R7 rate3 early", int'(v), 8'h00);
        at_neg(64); rd(1, v); chk("R7 rate3 hit", int'(v), 8'h40);
        rate_sel = 2'd1; wr_reg(1, 8'h40);
        at_neg(72); rd(1, v); chk("R7 rate1 skip", int'(v), 8'h00);
        at_neg(79); rd(1, v); chk("R7 rate1 early", int'(v), 8'h00);
        at_neg(80); rd(1, v); chk("R7 rate1 hit", int'(v), 8'h40);

        // Mixed traffic, checked by the model every cycle.
        for (int k = 0; k < 4000; k++) begin
            reg_wr      = (($urandom % 4) == 0);
            reg_sel     = $urandom % 2;
            reg_wdata   = 8'($urandom);
            ovf_set     = (($urandom % 16) == 0);
            pa_ovf_set  = (($urandom % 16) == 0);
            pa_edge_set = (($urandom % 16) == 0);
            if (($urandom % 64) == 0) rate_sel = 2'($urandom);
            @(negedge clk); #1;
        end
        reg_wr = 1'b0; ovf_set = 1'b0; pa_ovf_set = 1'b0; pa_edge_set = 1'b0;
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule